// File: doc/BRIEF.md
# Splittable Two-Half Program Sequencer

This block sequences the program counter and the configuration-memory address of a reconfigurable compute array. The array can run one thread over its full width or split into two halves that each run a thread of their own. Each half has an identical sequencer core. The first half is always the master and the second half is always the slave.

In single-thread mode, a merge stage combines the branch and stall requests from both halves into one global decision for the master core. A bypass stage then sends the master's program counter and configuration address to the slave's outputs. In dual-thread mode, each core responds only to its own half's requests.

The mode changes only when a split request or a join request arrives. Because every port is a control or status pin, there is no valid/ready stream and no back-pressure path. Stall is the only hold mechanism, and it is sampled on every cycle. The merge and bypass stages are built to be instantiated again inside either half, so a half can be divided further.

Top module: `pcc_split_ctrl`

## Requirements
- R1: A synchronous reset puts the block in single-thread mode (`dual_mode` = 0) with `m_pc`, `m_cfg`, `s_pc` and `s_cfg` all zero.
- R2: In single-thread mode with no stall from either half, a branch from either half loads that half's target into the master PC on the next clock. If both halves branch in the same cycle, the master's target is used.
- R3: In single-thread mode, a stall from either half keeps the master PC and configuration address unchanged on the next clock. A stall overrides any branch raised in the same cycle.
- R4: In single-thread mode, `s_pc` and `s_cfg` equal `m_pc` and `m_cfg` in every cycle.
- R5: When a core is not stalled and not loading, its PC advances by one, modulo 2^PC_W. Its configuration address also advances by one and wraps from CFG_DEPTH-1 to 0. When a core loads a target T, its configuration address becomes T mod CFG_DEPTH.
- R6: In dual-thread mode, each half acts only on its own branch, target and stall inputs. The other half's inputs have no effect on it.
- R7: A split request in single-thread mode sets `dual_mode` on the next clock. On that same clock, `s_pc` takes `start_pc` and `s_cfg` takes `start_pc` mod CFG_DEPTH. A split request in dual-thread mode is ignored.
- R8: A join request in dual-thread mode clears `dual_mode` on the next clock. From that cycle on, the slave outputs follow the master, and the slave's own PC is discarded. A join request in single-thread mode is ignored.
- R9: `dual_mode` is 1 exactly while the block is in dual-thread mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| split_req | input | 1 | Thread-start request; splits the array |
| join_req | input | 1 | Thread-join request; fuses the halves |
| start_pc | input | PC_W | Slave start address used on a split |
| m_branch | input | 1 | Master-half change-of-flow request |
| m_target | input | PC_W | Master-half branch target |
| m_stall | input | 1 | Master-half stall |
| s_branch | input | 1 | Slave-half change-of-flow request |
| s_target | input | PC_W | Slave-half branch target |
| s_stall | input | 1 | Slave-half stall |
| m_pc | output | PC_W | Master-half program counter |
| m_cfg | output | $clog2(CFG_DEPTH) | Master-half configuration address |
| s_pc | output | PC_W | Slave-half program counter |
| s_cfg | output | $clog2(CFG_DEPTH) | Slave-half configuration address |
| dual_mode | output | 1 | 1 while the array runs split |

## Verification
Every PC, configuration address and mode result is registered. Each one is therefore due exactly one clock edge after the edge that samples its stimulus. The slave outputs in single-thread mode are the exception: they are a mux on the mode register and follow the master in the same cycle. The bench drives its inputs just after a falling edge and updates its arithmetic model for the next rising edge. It then compares every output at the following falling edge, so each check lands one edge after its stimulus. The checker module tests the same one-edge relations with `|=>` properties.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic { MODE_SINGLE = 1'b0, MODE_DUAL = 1'b1 } pcc_mode_e;

  typedef struct packed {
    logic load;
    logic hold;
  } pcc_step_t;
endpackage

// File: rtl/pcc_core.sv
module pcc_core #(
  parameter int PC_W      = 8,
  parameter int CFG_DEPTH = 12,
  localparam int CFG_AW   = (CFG_DEPTH > 1) ? $clog2(CFG_DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pcc_pkg::pcc_step_t   step,
  input  logic [PC_W-1:0]      load_pc,
  output logic [PC_W-1:0]      pc,
  output logic [CFG_AW-1:0]    cfg
);
  localparam logic [CFG_AW-1:0] CFG_LAST = CFG_AW'(CFG_DEPTH - 1);
  localparam logic [PC_W-1:0]   DEPTH_PC = PC_W'(CFG_DEPTH);

  logic [PC_W-1:0] load_mod;
  assign load_mod = load_pc % DEPTH_PC;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      cfg <= '0;
    end else if (step.load) begin
      pc  <= load_pc;
      cfg <= load_mod[CFG_AW-1:0];
    end else if (!step.hold) begin
      pc  <= pc + PC_W'(1);
      cfg <= (cfg == CFG_LAST) ? '0 : cfg + CFG_AW'(1);
    end
  end
endmodule

// File: rtl/pcc_merger.sv
module pcc_merger #(
  parameter int PC_W = 8
) (
  input  pcc_pkg::pcc_mode_e  mode,
  input  logic                split_req,
  input  logic [PC_W-1:0]     start_pc,
  input  logic                m_branch,
  input  logic [PC_W-1:0]     m_target,
  input  logic                m_stall,
  input  logic                s_branch,
  input  logic [PC_W-1:0]     s_target,
  input  logic                s_stall,
  output pcc_pkg::pcc_step_t  m_step,
  output logic [PC_W-1:0]     m_load_pc,
  output pcc_pkg::pcc_step_t  s_step,
  output logic [PC_W-1:0]     s_load_pc
);
  import pcc_pkg::*;

  logic single;
  logic g_stall, g_branch;

  assign single   = (mode == MODE_SINGLE);
  assign g_stall  = m_stall  | (single & s_stall);
  assign g_branch = m_branch | (single & s_branch);

  always_comb begin
    m_step.hold = g_stall;
    m_step.load = g_branch & ~g_stall;
    m_load_pc   = (m_branch || !single) ? m_target : s_target;
    if (single) begin
      s_step.load = split_req;
      s_step.hold = 1'b1;
      s_load_pc   = start_pc;
    end else begin
      s_step.load = s_branch & ~s_stall;
      s_step.hold = s_stall;
      s_load_pc   = s_target;
    end
  end
endmodule

// File: rtl/pcc_bypass.sv
module pcc_bypass #(
  parameter int PC_W   = 8,
  parameter int CFG_AW = 4
) (
  input  pcc_pkg::pcc_mode_e mode,
  input  logic [PC_W-1:0]    mst_pc,
  input  logic [CFG_AW-1:0]  mst_cfg,
  input  logic [PC_W-1:0]    loc_pc,
  input  logic [CFG_AW-1:0]  loc_cfg,
  output logic [PC_W-1:0]    out_pc,
  output logic [CFG_AW-1:0]  out_cfg
);
  import pcc_pkg::*;

  always_comb begin
    if (mode == MODE_SINGLE) begin
      out_pc  = mst_pc;
      out_cfg = mst_cfg;
    end else begin
      out_pc  = loc_pc;
      out_cfg = loc_cfg;
    end
  end
endmodule

// File: rtl/pcc_split_ctrl.sv
module pcc_split_ctrl #(
  parameter int PC_W      = 8,
  parameter int CFG_DEPTH = 12,
  localparam int CFG_AW   = (CFG_DEPTH > 1) ? $clog2(CFG_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              split_req,
  input  logic              join_req,
  input  logic [PC_W-1:0]   start_pc,
  input  logic              m_branch,
  input  logic [PC_W-1:0]   m_target,
  input  logic              m_stall,
  input  logic              s_branch,
  input  logic [PC_W-1:0]   s_target,
  input  logic              s_stall,
  output logic [PC_W-1:0]   m_pc,
  output logic [CFG_AW-1:0] m_cfg,
  output logic [PC_W-1:0]   s_pc,
  output logic [CFG_AW-1:0] s_cfg,
  output logic              dual_mode
);
  import pcc_pkg::*;

  pcc_mode_e        mode_q;
  pcc_step_t        m_step, s_step;
  logic [PC_W-1:0]  m_ld, s_ld;
  logic [PC_W-1:0]  s_loc_pc;
  logic [CFG_AW-1:0] s_loc_cfg;

  always_ff @(posedge clk) begin
    if (rst)                                  mode_q <= MODE_SINGLE;
    else if (mode_q == MODE_SINGLE && split_req) mode_q <= MODE_DUAL;
    else if (mode_q == MODE_DUAL && join_req)    mode_q <= MODE_SINGLE;
  end

  assign dual_mode = (mode_q == MODE_DUAL);

  pcc_merger #(.PC_W(PC_W)) merge_i (
    .mode(mode_q), .split_req(split_req), .start_pc(start_pc),
    .m_branch(m_branch), .m_target(m_target), .m_stall(m_stall),
    .s_branch(s_branch), .s_target(s_target), .s_stall(s_stall),
    .m_step(m_step), .m_load_pc(m_ld), .s_step(s_step), .s_load_pc(s_ld)
  );

  pcc_core #(.PC_W(PC_W), .CFG_DEPTH(CFG_DEPTH)) mcore_i (
    .clk(clk), .rst(rst), .step(m_step), .load_pc(m_ld), .pc(m_pc), .cfg(m_cfg)
  );

  pcc_core #(.PC_W(PC_W), .CFG_DEPTH(CFG_DEPTH)) score_i (
    .clk(clk), .rst(rst), .step(s_step), .load_pc(s_ld), .pc(s_loc_pc), .cfg(s_loc_cfg)
  );

  pcc_bypass #(.PC_W(PC_W), .CFG_AW(CFG_AW)) byp_i (
    .mode(mode_q), .mst_pc(m_pc), .mst_cfg(m_cfg),
    .loc_pc(s_loc_pc), .loc_cfg(s_loc_cfg), .out_pc(s_pc), .out_cfg(s_cfg)
  );
endmodule

// File: rtl/pcc_split_ctrl_chk.sv
module pcc_split_ctrl_chk #(
  parameter int PC_W      = 8,
  parameter int CFG_DEPTH = 12,
  localparam int CFG_AW   = (CFG_DEPTH > 1) ? $clog2(CFG_DEPTH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              split_req,
  input logic              join_req,
  input logic [PC_W-1:0]   start_pc,
  input logic              m_branch,
  input logic [PC_W-1:0]   m_target,
  input logic              m_stall,
  input logic              s_branch,
  input logic [PC_W-1:0]   s_target,
  input logic              s_stall,
  input logic [PC_W-1:0]   m_pc,
  input logic [CFG_AW-1:0] m_cfg,
  input logic [PC_W-1:0]   s_pc,
  input logic [CFG_AW-1:0] s_cfg,
  input logic              dual_mode
);
  p_master_wins_r2: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && !m_stall && !s_stall && m_branch) |=> (m_pc == $past(m_target)));

  p_slave_branch_r2: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && !m_stall && !s_stall && !m_branch && s_branch) |=> (m_pc == $past(s_target)));

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && (m_stall || s_stall)) |=> ($stable(m_pc) && $stable(m_cfg)));

  p_follow_r4: assert property (@(posedge clk) disable iff (rst)
    !dual_mode |-> (s_pc == m_pc && s_cfg == m_cfg));

  p_cfg_range_r5: assert property (@(posedge clk) disable iff (rst)
    (32'(m_cfg) < CFG_DEPTH) && (32'(s_cfg) < CFG_DEPTH));

  p_dual_isolate_r6: assert property (@(posedge clk) disable iff (rst)
    (dual_mode && !m_stall && !m_branch) |=> (m_pc == $past(m_pc) + PC_W'(1)));

  p_split_r7: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && split_req) |=> (dual_mode && s_pc == $past(start_pc)));

  p_join_r8: assert property (@(posedge clk) disable iff (rst)
    (dual_mode && join_req) |=> !dual_mode);
endmodule

bind pcc_split_ctrl pcc_split_ctrl_chk #(.PC_W(PC_W), .CFG_DEPTH(CFG_DEPTH)) chk_i (.*);

// File: tb/pcc_split_ctrl_tb.sv
module pcc_split_ctrl_tb_top;
  localparam int PC_W = 8;
  localparam int D    = 12;
  localparam int AW   = $clog2(D);

  logic clk = 1'b0;
  logic rst;
  logic split_req, join_req, m_branch, m_stall, s_branch, s_stall;
  logic [PC_W-1:0] start_pc, m_target, s_target;
  logic [PC_W-1:0] m_pc, s_pc;
  logic [AW-1:0]   m_cfg, s_cfg;
  logic dual_mode;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  int e_md, e_pm, e_cm, e_xs, e_xc;

  always #2.5 clk = ~clk;

  pcc_split_ctrl #(.PC_W(PC_W), .CFG_DEPTH(D)) dut_i (.*);

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "dual_mode", int'(dual_mode), e_md);
    chk(tag, "m_pc", int'(m_pc), e_pm);
    chk(tag, "m_cfg", int'(m_cfg), e_cm);
    chk(tag, "s_pc", int'(s_pc), e_md ? e_xs : e_pm);
    chk(tag, "s_cfg", int'(s_cfg), e_md ? e_xc : e_cm);
  endtask

  // Drive at a falling edge, predict the next rising edge, compare at the next falling edge.
  task automatic step(string tag, bit sp, bit jn, int st, bit mb, int mt, bit ms,
                      bit sb, int sgt, bit ss);
    bit gs, gb;
    int gt;
    split_req = sp; join_req = jn; start_pc = PC_W'(st);
    m_branch = mb; m_target = PC_W'(mt); m_stall = ms;
    s_branch = sb; s_target = PC_W'(sgt); s_stall = ss;
    gs = e_md ? ms : (ms | ss);
    gb = e_md ? mb : (mb | sb);
    gt = (mb || e_md) ? mt : sgt;
    if (!gs) begin
      if (gb) begin e_pm = gt % 256; e_cm = e_pm % D; end
      else begin e_pm = (e_pm + 1) % 256; e_cm = (e_cm + 1) % D; end
    end
    if (e_md == 0) begin
      if (sp) begin e_xs = st % 256; e_xc = e_xs % D; e_md = 1; end
    end else begin
      if (!ss) begin
        if (sb) begin e_xs = sgt % 256; e_xc = e_xs % D; end
        else begin e_xs = (e_xs + 1) % 256; e_xc = (e_xc + 1) % D; end
      end
      if (jn) e_md = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    split_req = 0; join_req = 0; start_pc = '0;
    m_branch = 0; m_target = '0; m_stall = 0;
    s_branch = 0; s_target = '0; s_stall = 0;
    e_md = 0; e_pm = 0; e_cm = 0; e_xs = 0; e_xc = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst = 1'b0;

    // R5: free run through several configuration wraps
    for (int i = 0; i < 30; i++) step("R5", 0,0,0, 0,0,0, 0,0,0);
    // R4 with R2: slave branch in single mode
    step("R2", 0,0,0, 0,0,0, 1,77,0);
    step("R4", 0,0,0, 0,0,0, 0,0,0);
    // R2: both branch, master wins
    step("R2", 0,0,0, 1,200,0, 1,9,0);
    // R3: stall from slave overrides branch; then stall from master
    step("R3", 0,0,0, 1,5,0, 0,0,1);
    step("R3", 0,0,0, 0,0,1, 1,6,0);
    // R8: join in single ignored
    step("R8", 0,1,0, 0,0,0, 0,0,0);
    // R7: split
    step("R7", 1,0,130,0,0,0, 0,0,0);
    step("R9", 0,0,0, 0,0,0, 0,0,0);
    // R7: split while dual ignored
    step("R7", 1,0,3, 0,0,0, 0,0,0);
    // R6: independence in both directions
    step("R6", 0,0,0, 0,0,0, 0,0,1);
    step("R6", 0,0,0, 0,0,1, 1,40,0);
    step("R6", 0,0,0, 1,250,0, 0,0,0);
    for (int i = 0; i < 14; i++) step("R6", 0,0,0, 0,0,0, 0,0,0);
    // R8: join, slave follows master
    step("R8", 0,1,0, 0,0,0, 1,99,0);
    step("R8", 0,0,0, 0,0,0, 0,0,0);

    // Sweep of mixed stimulus over both modes
    for (int i = 0; i < 4000; i++) begin
      bit sp, jn, mb, ms, sb, ss;
      sp = ($urandom % 16) == 0;
      jn = ($urandom % 16) == 0;
      mb = ($urandom % 5) == 0;
      ms = ($urandom % 6) == 0;
      sb = ($urandom % 5) == 0;
      ss = ($urandom % 6) == 0;
      step(e_md ? "R6" : "R2", sp, jn, int'($urandom % 256), mb, int'($urandom % 256), ms,
           sb, int'($urandom % 256), ss);
    end

    // R1: reset mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    e_md = 0; e_pm = 0; e_cm = 0;
    check_all("R1");
    rst = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule